// File: doc/BRIEF.md
# Touch Converter I2C Slave Interface

This block is the serial front end of a resistive touch-screen digitizer. It watches the two bus lines as a target device. It recognises bus conditions and decodes the device address. It takes in one command byte per write transaction and hands the decoded command to the converter core. On read transactions it sends the latest conversion result back to the bus master. The bus lines are oversampled by a fast system clock. The block drives each line only by pulling it low, through an output-enable.

A write delivers the command. Once the command byte is taken, the block pulses a strobe that tells the core to begin acquisition. When the acknowledge clock ends, it pulses a second strobe that tells the core to begin conversion. The core returns its result together with a done pulse, and the block stores it in a holding register. If a master asks for data before a result is held, the block keeps the clock line low until the result arrives. The result is sent left-justified in two bytes, and the pair repeats for as long as the master keeps acknowledging.

Top module: `touch_i2c_slave`

## Requirements
- R1: The address byte is sent MSB first and is read as prefix 1,0,0,1,0 in bits 7..3, then the two strap pins (bit 2 = addr_pins[1], bit 1 = addr_pins[0]), then the direction in bit 0 (1 = read). The block pulls SDA low in the ninth clock only when bits 7..1 match. On a mismatch it leaves SDA released for the rest of the transaction.
- R2: On a write, the first byte after the address is acknowledged and then appears on the command outputs: cmd_chan = bits 7..4, cmd_pd = bits 3..2, cmd_8bit = bit 1. Bit 0 has no effect.
- R3: Every byte after the command byte in the same write is not acknowledged, and the command outputs keep their values.
- R4: acq_start pulses for one cycle when the eighth command bit is complete. conv_start pulses for one cycle later, when the acknowledge clock of the command byte ends. The two never pulse in the same cycle.
- R5: A read sends bits 11..4 of the held result as the first byte. The second byte is bits 3..0 followed by four zero bits. Both bytes are sent MSB first.
- R6: When cmd_8bit is 1, the first byte is unchanged and the second byte is 0x00.
- R7: If the master acknowledges the second byte, the two-byte pattern starts again. After a master not-acknowledge, SDA stays released until the next START.
- R8: A byte of the form 00001xxx after START (the high-speed master code) is not acknowledged. A repeated START that follows it is then addressed normally.
- R9: A read can be addressed while no result has been captured since the last command. In that case SCL is held low after the address acknowledge until conv_done arrives, and it is released with the first data bit already on SDA.
- R10: The result is captured only in a cycle where conv_done is 1. Later reads return the held value with no stretching, even if conv_result changes.
- R11: SDA output changes only while SCL is low. A STOP returns the block to idle, so bytes clocked without a START are ignored. A (repeated) START always restarts address reception.
- R12: After reset, both line drivers are released, the strobes are low and the command outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_pins | input | PIN_W | Strap pins forming the low address bits |
| conv_result | input | RES_W | Conversion result from the core |
| conv_done | input | 1 | Result-valid pulse from the core |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| cmd_chan | output | 4 | Channel select field of the command |
| cmd_pd | output | 2 | Power-down field of the command |
| cmd_8bit | output | 1 | 8-bit resolution select |
| acq_start | output | 1 | Start-acquisition strobe |
| conv_start | output | 1 | Start-conversion strobe |

## Verification
The bench models an open-drain bus with a master that waits whenever the clock line is held low. This lets it count exactly how long the block stretches. One test requests a read before any result exists and delivers conv_done only during the stretch. A design that loaded the shift register too early would send stale zeros, and one that never stretched would show a zero stretch count. Other tests send a second write byte, the high-speed master code followed by a repeated START, and a master NACK followed by more clocks. A design that acknowledged extra bytes, latched the master code as an address, or kept driving after the NACK would show a wrong ACK bit or data other than 0xFF. Reading again after conv_result changes without conv_done exposes a holding register that follows its input.

// File: rtl/touch_i2c_pkg.sv
// Shared types for the touch converter I2C slave.
// Assumes: nothing beyond the standard language.
package touch_i2c_pkg;

    // Transaction phases of the slave engine.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_STRETCH,
        ST_RD_BIT,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_t;

endpackage

// File: rtl/tsi_line_sync.sv
// Synchronises SCL and SDA into the system clock.
// Flags SCL edges and START/STOP conditions.
// Assumes: the system clock is many times faster than SCL; the lines idle high.
module tsi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, sda_m, scl_d, sda_d;

    // Two-flop synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_d} <= 3'b111;
            {sda_m, sda_s, sda_d} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_d} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_d} <= {sda_i, sda_m, sda_s};
        end
    end

    // SCL edges and SDA transitions while SCL stays high.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/tsi_addr_match.sv
// Compares a received address byte with the fixed prefix and the strap pins.
// Assumes: the prefix and pins together fill bits 7..1 and bit 0 is the direction.
module tsi_addr_match #(
    parameter int               PIN_W  = 2,
    parameter logic [6-PIN_W:0] PREFIX = 5'b10010
) (
    input  logic [7:0]       addr_byte,
    input  logic [PIN_W-1:0] pins,
    output logic             hit,
    output logic             rd
);
    // Match prefix and pins; bit 0 carries the direction.
    always_comb begin
        hit = (addr_byte[7:1] == {PREFIX, pins});
        rd  = addr_byte[0];
    end
endmodule

// File: rtl/tsi_result_fmt.sv
// Splits a held result into the two left-justified bytes sent on reads.
// Assumes: 9 <= RES_W <= 16.
module tsi_result_fmt #(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] res,
    input  logic             mode8,
    output logic [7:0]       hi_byte,
    output logic [7:0]       lo_byte
);
    localparam int LO_BITS  = RES_W - 8;
    localparam int PAD_BITS = 8 - LO_BITS;

    // High byte always carries the top eight bits; low byte is blanked in 8-bit mode.
    always_comb begin
        hi_byte = res[RES_W-1 -: 8];
        lo_byte = mode8 ? 8'h00 : {res[LO_BITS-1:0], {PAD_BITS{1'b0}}};
    end
endmodule

// File: rtl/touch_i2c_slave.sv
// I2C target front end for a touch-screen converter. It decodes the address,
// takes one command byte per write, strobes acquisition and conversion, and
// returns the held result on reads, stretching SCL until a result exists.
// Assumes: clk oversamples SCL by at least 8x; pads are open-drain, driven by the *_oe outputs.
module touch_i2c_slave
    import touch_i2c_pkg::*;
#(
    parameter int               RES_W       = 12,
    parameter int               PIN_W       = 2,
    parameter logic [6-PIN_W:0] ADDR_PREFIX = 5'b10010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [PIN_W-1:0] addr_pins,
    input  logic [RES_W-1:0] conv_result,
    input  logic             conv_done,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic [3:0]       cmd_chan,
    output logic [1:0]       cmd_pd,
    output logic             cmd_8bit,
    output logic             acq_start,
    output logic             conv_start
);
    localparam int          BYTE_BITS = 8;
    localparam int          CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_state_t       state;
    logic [7:0]       sh;
    logic [CNT_W-1:0] bit_cnt;
    logic             rw, mack, byte_sel;
    logic [RES_W-1:0] hold_q;
    logic             res_ready;
    logic             addr_hit, addr_rd;
    logic [7:0]       hi_byte, lo_byte, next_byte;
    logic             cmd_take;

    tsi_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tsi_addr_match #(.PIN_W(PIN_W), .PREFIX(ADDR_PREFIX)) u_match (
        .addr_byte(sh), .pins(addr_pins), .hit(addr_hit), .rd(addr_rd)
    );

    tsi_result_fmt #(.RES_W(RES_W)) u_fmt (
        .res(hold_q), .mode8(cmd_8bit), .hi_byte(hi_byte), .lo_byte(lo_byte)
    );

    // Command byte complete, and the byte to load after a master ACK.
    always_comb begin
        cmd_take  = (state == ST_CMD) && scl_fall && (bit_cnt == FULL) && !start_det && !stop_det;
        next_byte = byte_sel ? hi_byte : lo_byte;
    end

    // Holding register: capture on done, invalidate when a new command arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            res_ready <= 1'b0;
        end else if (cmd_take) begin
            res_ready <= 1'b0;
        end else if (conv_done) begin
            hold_q    <= conv_result;
            res_ready <= 1'b1;
        end
    end

    // Transaction engine: bus conditions first, then per-phase bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sh         <= '0;
            bit_cnt    <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            byte_sel   <= 1'b0;
            sda_oe     <= 1'b0;
            scl_oe     <= 1'b0;
            cmd_chan   <= '0;
            cmd_pd     <= '0;
            cmd_8bit   <= 1'b0;
            acq_start  <= 1'b0;
            conv_start <= 1'b0;
        end else begin
            acq_start  <= 1'b0;
            conv_start <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                scl_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                scl_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD: begin
                        if (scl_rise) begin
                            sh      <= {sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && bit_cnt == FULL) begin
                            if (state == ST_CMD) begin
                                cmd_chan  <= sh[7:4];
                                cmd_pd    <= sh[3:2];
                                cmd_8bit  <= sh[1];
                                acq_start <= 1'b1;
                                sda_oe    <= 1'b1;
                                state     <= ST_CMD_ACK;
                            end else if (addr_hit) begin
                                rw     <= addr_rd;
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt  <= '0;
                            byte_sel <= 1'b0;
                            if (!rw) begin
                                sda_oe <= 1'b0;
                                state  <= ST_CMD;
                            end else if (res_ready) begin
                                sh     <= hi_byte;
                                sda_oe <= ~hi_byte[7];
                                state  <= ST_RD_BIT;
                            end else begin
                                sda_oe <= 1'b0;
                                scl_oe <= 1'b1;
                                state  <= ST_STRETCH;
                            end
                        end
                    end
                    ST_CMD_ACK: begin
                        if (scl_fall) begin
                            sda_oe     <= 1'b0;
                            conv_start <= 1'b1;
                            state      <= ST_IGNORE;
                        end
                    end
                    ST_STRETCH: begin
                        if (res_ready) begin
                            sh     <= hi_byte;
                            sda_oe <= ~hi_byte[7];
                            state  <= ST_RD_BIT;
                        end
                    end
                    ST_RD_BIT: begin
                        scl_oe <= 1'b0;
                        if (scl_fall) begin
                            if (bit_cnt == LAST) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                sh      <= {sh[6:0], 1'b0};
                                sda_oe  <= ~sh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                byte_sel <= ~byte_sel;
                                bit_cnt  <= '0;
                                sh       <= next_byte;
                                sda_oe   <= ~next_byte[7];
                                state    <= ST_RD_BIT;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_SDA_LAUNCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R11
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_oe && !scl_oe)); // R11
    AST_ACQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !acq_start && !conv_start); // R4
    AST_STRETCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !$past(res_ready)); // R9
    AST_STRETCH_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $past(res_ready)); // R9
endmodule

// File: tb/touch_i2c_slave_tb.sv
module touch_i2c_slave_tb;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic [1:0]  addr_pins = 2'b10;
    logic [11:0] conv_result = '0;
    logic        conv_done = 1'b0;
    logic        scl_oe, sda_oe, cmd_8bit, acq_start, conv_start;
    logic [3:0]  cmd_chan;
    logic [1:0]  cmd_pd;
    wire         scl_line = !(m_scl_low || scl_oe);
    wire         sda_line = !(m_sda_low || sda_oe);

    int n_chk = 0, n_fail = 0, stretch = 0;
    int acq_cnt = 0, conv_cnt = 0;
    longint cyc = 0, acq_t = 0, conv_t = 0;
    logic        r_ack;
    logic [7:0]  r_b0, r_b1, r_b2, r_b3, r_b4;

    always #2 clk = ~clk;

    touch_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .addr_pins(addr_pins), .conv_result(conv_result), .conv_done(conv_done),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cmd_chan(cmd_chan), .cmd_pd(cmd_pd),
        .cmd_8bit(cmd_8bit), .acq_start(acq_start), .conv_start(conv_start)
    );

    always @(posedge clk) begin
        cyc++;
        if (acq_start)  begin acq_cnt++;  acq_t = cyc;  end
        if (conv_start) begin conv_cnt++; conv_t = cyc; end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) begin stretch++; @(negedge clk); end
    endtask

    task automatic start_c();
        m_sda_low = 1'b0; waitc(H);
        scl_up(); waitc(H);
        m_sda_low = 1'b1; waitc(H);
        m_scl_low = 1'b1; waitc(H);
    endtask

    task automatic stop_c();
        m_sda_low = 1'b1; waitc(H);
        scl_up(); waitc(H);
        m_sda_low = 1'b0; waitc(H);
    endtask

    task automatic bit_c(input logic b, output logic r);
        m_sda_low = ~b; waitc(H);
        scl_up(); waitc(H);
        r = sda_line;
        m_scl_low = 1'b1; waitc(H);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_c(d[i], r);
        bit_c(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin bit_c(1'b1, r); d[i] = r; end
        bit_c(~give_ack, r);
    endtask

    task automatic pulse_done(input logic [11:0] v);
        @(negedge clk); conv_result = v; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    task automatic write_cmd(input logic [7:0] c);
        logic a;
        start_c(); send_byte(8'h94, a); send_byte(c, a); stop_c();
    endtask

    task automatic t_reset();
        chk("R12 sda_oe", sda_oe, 0);
        chk("R12 scl_oe", scl_oe, 0);
        chk("R12 strobes", acq_cnt + conv_cnt, 0);
        chk("R12 cmd", {cmd_chan, cmd_pd, cmd_8bit}, 0);
    endtask

    task automatic t_addr_mismatch();
        start_c();
        send_byte(8'h92, r_ack); chk("R1 mismatch nack", r_ack, 0);
        send_byte(8'h30, r_ack); chk("R1 stays released", r_ack, 0);
        stop_c();
        chk("R1 no command", acq_cnt, 0);
    endtask

    task automatic t_write_cmd();
        int a0 = acq_cnt, c0 = conv_cnt;
        start_c();
        send_byte(8'h94, r_ack); chk("R1 match ack", r_ack, 1);
        send_byte(8'hB6, r_ack); chk("R2 cmd ack", r_ack, 1);
        chk("R2 chan", cmd_chan, 4'hB);
        chk("R2 pd", cmd_pd, 2'd1);
        chk("R2 mode8", cmd_8bit, 1);
        chk("R4 acq once", acq_cnt - a0, 1);
        chk("R4 conv once", conv_cnt - c0, 1);
        chk("R4 order", int'(conv_t > acq_t), 1);
        send_byte(8'h5A, r_ack); chk("R3 extra nack", r_ack, 0);
        chk("R3 cmd kept", {cmd_chan, cmd_pd, cmd_8bit}, {4'hB, 2'd1, 1'b1});
        chk("R3 no strobe", acq_cnt - a0, 1);
        stop_c();
    endtask

    task automatic t_read_stretch();
        write_cmd(8'h30);
        chk("R2 12-bit", cmd_8bit, 0);
        start_c();
        stretch = 0;
        fork
            begin
                send_byte(8'h95, r_ack);
                recv_byte(1'b1, r_b0); recv_byte(1'b1, r_b1);
                recv_byte(1'b1, r_b2); recv_byte(1'b0, r_b3);
                recv_byte(1'b1, r_b4);
            end
            begin waitc(1000); pulse_done(12'hA5C); end
        join
        stop_c();
        chk("R9 read ack", r_ack, 1);
        chk("R9 stretched", int'(stretch > 0), 1);
        chk("R5 byte0", r_b0, 8'hA5);
        chk("R5 byte1", r_b1, 8'hC0);
        chk("R7 repeat0", r_b2, 8'hA5);
        chk("R7 repeat1", r_b3, 8'hC0);
        chk("R7 released after nack", r_b4, 8'hFF);
        conv_result = 12'h111;
        stretch = 0;
        start_c();
        send_byte(8'h95, r_ack); recv_byte(1'b1, r_b0); recv_byte(1'b0, r_b1);
        stop_c();
        chk("R10 no stretch", stretch, 0);
        chk("R10 held byte0", r_b0, 8'hA5);
        chk("R10 held byte1", r_b1, 8'hC0);
    endtask

    task automatic t_mode8();
        write_cmd(8'h02);
        chk("R6 mode8 set", cmd_8bit, 1);
        pulse_done(12'h3C7);
        start_c();
        send_byte(8'h95, r_ack); recv_byte(1'b1, r_b0); recv_byte(1'b0, r_b1);
        stop_c();
        chk("R6 byte0", r_b0, 8'h3C);
        chk("R6 byte1 zero", r_b1, 8'h00);
    endtask

    task automatic t_hs_code();
        start_c();
        send_byte(8'h0A, r_ack); chk("R8 master code nack", r_ack, 0);
        start_c();
        send_byte(8'h95, r_ack); chk("R8 addr after Sr", r_ack, 1);
        recv_byte(1'b0, r_b0);
        stop_c();
        chk("R8 data after Sr", r_b0, 8'h3C);
    endtask

    task automatic t_stop_idle();
        start_c(); send_byte(8'h94, r_ack); stop_c();
        chk("R11 idle release", sda_oe, 0);
        send_byte(8'h94, r_ack); chk("R11 no start ignored", r_ack, 0);
        stop_c();
        start_c(); send_byte(8'h94, r_ack); chk("R11 restart ack", r_ack, 1);
        stop_c();
    endtask

    initial begin
        waitc(150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset();
        t_addr_mismatch();
        t_write_cmd();
        t_read_stretch();
        t_mode8();
        t_hs_code();
        t_stop_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule